// File: doc/BRIEF.md
# Unidirectional Scaling-Free Rotation Pipeline

This block rotates a 16-bit two's-complement vector (x, y) through a small angle that has already been folded into the range 0 to about pi/8 radians. Each elementary section multiplies the vector by an approximately length-preserving rotation built only from shifts and adds, so the result needs no gain correction. All sections for one sample turn the same way, which is chosen by a direction bit. The angle itself is never computed on: each 1 bit of the 13-bit unsigned residual directly switches on the section or sections of matching weight. A section whose enable is clear forwards its input untouched.

Samples enter and leave through valid/ready streams at up to one per clock. A small side-band token (a 2-bit quadrant code, a 2-bit domain code and the direction bit) travels with each sample so that later logic can rebuild the full-circle result. The whole pipeline advances together: it moves whenever the output slot is empty or the consumer takes the output. When the consumer holds ready low with a valid output, nothing moves, `in_ready` drops, and the output stays unchanged until it is taken. A producer must hold its sample steady while `in_valid` is high and `in_ready` is low.

Top module: `rot_pipe`

## Requirements
- R1: While reset is held and after it is released with no input, `out_valid` is 0 and `in_ready` is 1.
- R2: With `out_ready` held at 1, a sample accepted on a clock edge appears on the outputs with `out_valid` high exactly 12 rising edges later.
- R3: A residual of zero returns x and y unchanged, bit for bit.
- R4: Each enabled section with index i computes, from the same old x and y, for direction 0: x' = x - (x>>>(2i+1)) - (y>>>i), y' = y - (y>>>(2i+1)) + (x>>>i). Here >>> is an arithmetic right shift and results wrap to 16 bits. Sections are applied in this order: all index-4 copies first, then indices 5 to 14 in ascending order.
- R5: Residual bit j has weight 2^(j-14) rad. Bits 12..10, read as an unsigned count n, enable min(n,6) copies of the index-4 section. Bit 14-i enables the section with index i for i = 5 to 14.
- R6: A count of 7 in bits 12..10 is handled as 6.
- R7: For indices 7 and above, the (2i+1)-shift terms are omitted. For example, (-16384, 0) with only bit 7 set and direction 0 gives exactly (-16384, -128).
- R8: The quadrant, domain and direction bits leave with the same sample they entered with.
- R9: While `out_valid` is 1 and `out_ready` is 0, every output holds its value. `in_ready` equals `out_ready` OR NOT `out_valid`. Samples are neither lost nor duplicated, and they keep their order.
- R10: For a residual up to 0x1922 and an input length up to 16384, each output coordinate is within 64 LSB of an ideal rotation by residual*2^-14 rad.
- R11: Direction 1 mirrors R4: the y>>>i term is added to x, and the x>>>i term is subtracted from y. The result is a clockwise rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Pipeline accepts the input this cycle |
| in_x | input | 16 | Input x, two's complement |
| in_y | input | 16 | Input y, two's complement |
| in_resid | input | 13 | Unsigned residual angle, bit j weighs 2^(j-14) rad |
| in_quad | input | 2 | Quadrant code, carried unchanged |
| in_domain | input | 2 | Domain code, carried unchanged |
| in_dir | input | 1 | Rotation direction: 0 counterclockwise, 1 clockwise |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_x | output | 16 | Rotated x |
| out_y | output | 16 | Rotated y |
| out_quad | output | 2 | Quadrant code of this sample |
| out_domain | output | 2 | Domain code of this sample |
| out_dir | output | 1 | Direction bit of this sample |

## Verification
A wrong enable bit, a misplaced section or a stage that drops its quadratic term changes the x or y value of the very sample that used it. That error reaches the ports 12 accepted cycles after the sample entered, and a bit-exact reference model catches it there. If the enable or token registers slip by one stage against the data, the next sample's residual or token is paired with the current sample's vector. This shows as a mismatch on the first pair of consecutive samples that differ. A fault in the stall logic shows on the cycle after `out_ready` first goes low, as an output that changes or vanishes before it is taken.

// File: rtl/rot_pkg.sv
`timescale 1ns/1ps
package rot_pkg;

  // side-band token that rides with every sample
  typedef struct packed {
    logic [1:0] quad;
    logic [1:0] domain;
    logic       dir;
  } rot_tok_t;

  // shift index of elementary section number k (copies of the base index first)
  function automatic int sec_index(input int k, input int base, input int rep);
    return (k < rep) ? base : base + k - rep + 1;
  endfunction

  // first section number handled by pipeline stage s
  function automatic int stage_first(input int s, input int nsolo);
    return (s < nsolo) ? s : nsolo + 2 * (s - nsolo);
  endfunction

  // number of sections merged into pipeline stage s
  function automatic int stage_width(input int s, input int nsolo);
    return (s < nsolo) ? 1 : 2;
  endfunction

endpackage

// File: rtl/rot_enable_decode.sv
`timescale 1ns/1ps
module rot_enable_decode #(
  parameter int RW       = 13,
  parameter int ONEPOS   = 14,
  parameter int BASE_IDX = 4,
  parameter int REP      = 6,
  parameter int MAX_IDX  = 14,
  localparam int NSEC    = REP + MAX_IDX - BASE_IDX,
  localparam int CW      = RW - (ONEPOS - BASE_IDX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RW-1:0]   resid,
  output logic [NSEC-1:0] en
);

  logic [CW-1:0] cnt;
  assign cnt = resid[RW-1 -: CW];

  // thermometer over the repeated base-index copies; saturates at REP
  for (genvar k = 0; k < REP; k++) begin : g_rep
    assign en[k] = (int'(cnt) > k);
  end

  // one residual bit per remaining index
  for (genvar i = BASE_IDX + 1; i <= MAX_IDX; i++) begin : g_one
    assign en[REP + i - BASE_IDX - 1] = resid[ONEPOS - i];
  end

  // R5: enabled copies always form a contiguous run from copy 0
  assert_therm_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en[REP-1:0] ^ (en[REP-1:0] >> 1)));

  // R6: an oversized count turns on every copy
  assert_therm_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) >= REP) |-> (&en[REP-1:0]));

endmodule

// File: rtl/rot_section.sv
`timescale 1ns/1ps
module rot_section #(
  parameter int W   = 16,
  parameter int IDX = 4
) (
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] y,
  input  logic                dir,
  input  logic                en,
  output logic signed [W-1:0] xo,
  output logic signed [W-1:0] yo
);

  localparam int QS = 2 * IDX + 1;

  logic signed [W-1:0] xq, yq, xc, yc, xr, yr;

  // second-order shrink term, dropped once the shift leaves only sign bits
  if (QS < W - 1) begin : g_quad
    assign xq = x >>> QS;
    assign yq = y >>> QS;
  end else begin : g_noquad
    assign xq = '0;
    assign yq = '0;
  end

  assign xc = y >>> IDX;
  assign yc = x >>> IDX;

  always_comb begin
    if (dir) begin
      xr = x - xq + xc;
      yr = y - yq - yc;
    end else begin
      xr = x - xq - xc;
      yr = y - yq + yc;
    end
  end

  assign xo = en ? xr : x;
  assign yo = en ? yr : y;

endmodule

// File: rtl/rot_stage.sv
`timescale 1ns/1ps
module rot_stage
  import rot_pkg::*;
#(
  parameter int W        = 16,
  parameter int NS       = 1,
  parameter int FIRST    = 0,
  parameter int BASE_IDX = 4,
  parameter int REP      = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] in_y,
  input  logic [NS-1:0]       in_en,
  input  rot_tok_t            in_tok,
  output logic                out_valid,
  output logic signed [W-1:0] out_x,
  output logic signed [W-1:0] out_y,
  output rot_tok_t            out_tok
);

  logic signed [W-1:0] cx [NS+1];
  logic signed [W-1:0] cy [NS+1];

  assign cx[0] = in_x;
  assign cy[0] = in_y;

  // NS sections chained inside one register stage
  for (genvar j = 0; j < NS; j++) begin : g_sec
    rot_section #(
      .W   (W),
      .IDX (sec_index(FIRST + j, BASE_IDX, REP))
    ) u_sec (
      .x   (cx[j]),
      .y   (cy[j]),
      .dir (in_tok.dir),
      .en  (in_en[j]),
      .xo  (cx[j+1]),
      .yo  (cy[j+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_tok   <= '0;
    end else if (adv) begin
      out_valid <= in_valid;
      out_x     <= cx[NS];
      out_y     <= cy[NS];
      out_tok   <= in_tok;
    end
  end

  // R2: a valid sample moves one stage per advancing cycle
  assert_stage_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv && in_valid |=> out_valid);

  // R9: a stalled stage keeps everything it holds
  assert_stage_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(out_valid) && $stable(out_x) && $stable(out_y) && $stable(out_tok));

endmodule

// File: rtl/rot_pipe.sv
`timescale 1ns/1ps
module rot_pipe
  import rot_pkg::*;
#(
  parameter int W         = 16,
  parameter int RW        = 13,
  parameter int BASE_IDX  = 4,
  parameter int REP       = 6,
  parameter int PAIR_FROM = 7,
  parameter int MAX_IDX   = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] in_y,
  input  logic [RW-1:0]       in_resid,
  input  logic [1:0]          in_quad,
  input  logic [1:0]          in_domain,
  input  logic                in_dir,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_x,
  output logic signed [W-1:0] out_y,
  output logic [1:0]          out_quad,
  output logic [1:0]          out_domain,
  output logic                out_dir
);

  localparam int ONEPOS  = W - 2;
  localparam int NSINGLE = PAIR_FROM - BASE_IDX - 1;
  localparam int NSOLO   = REP + NSINGLE;
  localparam int NPAIRED = MAX_IDX - PAIR_FROM + 1;
  localparam int NSTAGE  = NSOLO + NPAIRED / 2;
  localparam int NSEC    = REP + MAX_IDX - BASE_IDX;

  logic                adv;
  logic [NSEC-1:0]     dec_en;
  logic                sv [NSTAGE+1];
  logic signed [W-1:0] sx [NSTAGE+1];
  logic signed [W-1:0] sy [NSTAGE+1];
  rot_tok_t            st [NSTAGE+1];

  // whole pipeline moves when the last slot is empty or being taken
  assign adv      = out_ready | ~sv[NSTAGE];
  assign in_ready = adv;

  assign sv[0] = in_valid;
  assign sx[0] = in_x;
  assign sy[0] = in_y;
  assign st[0] = {in_quad, in_domain, in_dir};

  rot_enable_decode #(
    .RW       (RW),
    .ONEPOS   (ONEPOS),
    .BASE_IDX (BASE_IDX),
    .REP      (REP),
    .MAX_IDX  (MAX_IDX)
  ) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .resid (in_resid),
    .en    (dec_en)
  );

  for (genvar s = 0; s < NSTAGE; s++) begin : g_st
    localparam int F = stage_first(s, NSOLO);
    localparam int N = stage_width(s, NSOLO);

    // enables still needed from this stage onward, aligned with its data
    logic [NSEC-1:F] en_cur;

    if (s == 0) begin : g_src
      assign en_cur = dec_en;
    end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   en_cur <= '0;
        else if (adv) en_cur <= g_st[s-1].en_cur[NSEC-1:F];
      end
    end

    rot_stage #(
      .W        (W),
      .NS       (N),
      .FIRST    (F),
      .BASE_IDX (BASE_IDX),
      .REP      (REP)
    ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (adv),
      .in_valid  (sv[s]),
      .in_x      (sx[s]),
      .in_y      (sy[s]),
      .in_en     (en_cur[F +: N]),
      .in_tok    (st[s]),
      .out_valid (sv[s+1]),
      .out_x     (sx[s+1]),
      .out_y     (sy[s+1]),
      .out_tok   (st[s+1])
    );
  end

  assign out_valid  = sv[NSTAGE];
  assign out_x      = sx[NSTAGE];
  assign out_y      = sy[NSTAGE];
  assign out_quad   = st[NSTAGE].quad;
  assign out_domain = st[NSTAGE].domain;
  assign out_dir    = st[NSTAGE].dir;

  // R9: an offered output stays put until taken
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y)
      && $stable({out_quad, out_domain, out_dir}));

  // R9: an output only disappears after it was taken
  assert_out_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

endmodule

// File: tb/tb_rot_pipe.sv
`timescale 1ns/1ps
module tb_rot_pipe;

  localparam int LAT = 12;
  localparam real TOL = 64.0;

  typedef struct {
    int    x;
    int    y;
    int    tok;
    int    stamp;
    bit    lat;
    bit    acc;
    real   ix;
    real   iy;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n, in_valid, in_ready, in_dir, out_valid, out_ready, out_dir;
  logic signed [15:0] in_x, in_y, out_x, out_y;
  logic [12:0]        in_resid;
  logic [1:0]         in_quad, in_domain, out_quad, out_domain;

  int   total = 0, bad = 0, cyc = 0, n_in = 0, n_out = 0;
  bit   rand_ready = 0;
  bit   stall_prev = 0;
  int   px, py, ptok;
  exp_t q[$];
  exp_t e;

  rot_pipe dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_resid(in_resid),
    .in_quad(in_quad), .in_domain(in_domain), .in_dir(in_dir),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y),
    .out_quad(out_quad), .out_domain(out_domain), .out_dir(out_dir)
  );

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic int wrap16(input int v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  // one elementary step as the requirements define it
  task automatic step(inout int x, inout int y, input int i, input bit d);
    int xq, yq, xn, yn;
    xq = (2*i+1 < 15) ? (x >>> (2*i+1)) : 0;
    yq = (2*i+1 < 15) ? (y >>> (2*i+1)) : 0;
    if (!d) begin
      xn = x - xq - (y >>> i);
      yn = y - yq + (x >>> i);
    end else begin
      xn = x - xq + (y >>> i);
      yn = y - yq - (x >>> i);
    end
    x = wrap16(xn);
    y = wrap16(yn);
  endtask

  task automatic ref_rot(input int xi, input int yi, input logic [12:0] r,
                         input bit d, output int xo, output int yo);
    int x, y, n;
    x = xi; y = yi;
    n = int'(r[12:10]);
    if (n > 6) n = 6;
    for (int k = 0; k < n; k++) step(x, y, 4, d);
    for (int i = 5; i <= 14; i++) if (r[14-i]) step(x, y, i, d);
    xo = x; yo = y;
  endtask

  task automatic send(input int x, input int y, input logic [12:0] r,
                      input logic [1:0] qd, input logic [1:0] dm, input bit d,
                      input string tag, input bit acc);
    exp_t en;
    bit   took;
    real  th;
    @(posedge clk); #1;
    in_x = 16'(x); in_y = 16'(y); in_resid = r;
    in_quad = qd; in_domain = dm; in_dir = d; in_valid = 1'b1;
    took = 0;
    while (!took) begin
      @(negedge clk);
      took = in_ready;
    end
    ref_rot(x, y, r, d, en.x, en.y);
    en.tok   = int'({qd, dm, d});
    en.stamp = cyc;
    en.lat   = !rand_ready;
    en.acc   = acc;
    th = real'(int'(r)) * (2.0 ** -14);
    if (d) th = -th;
    en.ix  = real'(x) * $cos(th) - real'(y) * $sin(th);
    en.iy  = real'(x) * $sin(th) + real'(y) * $cos(th);
    en.tag = tag;
    q.push_back(en);
    n_in++;
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  // output monitor, compares on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        chk(out_valid && int'(out_x) == px && int'(out_y) == py
            && int'({out_quad, out_domain, out_dir}) == ptok,
            "R9", "output changed while stalled", int'(out_x), px);
      if (out_valid && out_ready) begin
        n_out++;
        if (q.size() == 0) chk(0, "R9", "unexpected output", int'(out_x), 0);
        else begin
          e = q.pop_front();
          chk(int'(out_x) == e.x, e.tag, "x", int'(out_x), e.x);
          chk(int'(out_y) == e.y, e.tag, "y", int'(out_y), e.y);
          chk(int'({out_quad, out_domain, out_dir}) == e.tok, "R8", "token",
              int'({out_quad, out_domain, out_dir}), e.tok);
          if (e.lat) chk(cyc - e.stamp == LAT, "R2", "latency", cyc - e.stamp, LAT);
          if (e.acc) begin
            chk((real'(int'(out_x)) - e.ix <= TOL) && (e.ix - real'(int'(out_x)) <= TOL),
                "R10", "x accuracy", int'(out_x), $rtoi(e.ix));
            chk((real'(int'(out_y)) - e.iy <= TOL) && (e.iy - real'(int'(out_y)) <= TOL),
                "R10", "y accuracy", int'(out_y), $rtoi(e.iy));
          end
        end
      end
      stall_prev = out_valid && !out_ready;
      px = int'(out_x); py = int'(out_y);
      ptok = int'({out_quad, out_domain, out_dir});
    end
  end

  // consumer ready: steady or random
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      out_ready = rand_ready ? 1'($urandom_range(1)) : 1'b1;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
    finish_up();
  end

  initial begin
    int rx, ry;
    logic [12:0] rr;
    bit rd;
    rst_n = 1'b0; in_valid = 1'b0; in_x = '0; in_y = '0; in_resid = '0;
    in_quad = '0; in_domain = '0; in_dir = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid idle after reset", int'(out_valid), 0);

    // directed corners, consumer always ready
    send(16384, 0, 13'h0000, 2'b10, 2'b01, 1'b0, "R3 R8", 1'b0);
    send(-12345, 7777, 13'h0000, 2'b01, 2'b11, 1'b1, "R3", 1'b0);
    send(16384, 0, 13'h1922, 2'b00, 2'b10, 1'b0, "R5 R10", 1'b1);
    send(4096, -8192, 13'h1C00, 2'b11, 2'b00, 1'b1, "R6 R11", 1'b0);
    send(-16384, 0, 13'h0080, 2'b00, 2'b00, 1'b0, "R7", 1'b0);
    send(0, 16384, 13'h0100, 2'b01, 2'b01, 1'b1, "R4 R11", 1'b0);
    send(10000, 5000, 13'h0A37, 2'b10, 2'b10, 1'b1, "R10 R11", 1'b1);
    send(16384, 0, 13'h0001, 2'b11, 2'b11, 1'b0, "R5 R7", 1'b0);
    for (int k = 0; k < 40; k++) begin
      rx = int'($urandom_range(22000)) - 11000;
      ry = int'($urandom_range(22000)) - 11000;
      rr = 13'($urandom_range(32'h1922));
      rd = 1'($urandom_range(1));
      send(rx, ry, rr, 2'(k), 2'(k >> 2), rd, "R4 R10", 1'b1);
    end
    for (int k = 0; k < 20; k++) begin
      rx = int'($urandom_range(22000)) - 11000;
      ry = int'($urandom_range(22000)) - 11000;
      rr = 13'($urandom);
      rd = 1'($urandom_range(1));
      send(rx, ry, rr, 2'(k + 1), 2'(k), rd, "R4 R5 R6", 1'b0);
    end
    idle(1);
    while (q.size() != 0) @(posedge clk);

    // random back-pressure with bursts and gaps
    rand_ready = 1;
    for (int k = 0; k < 200; k++) begin
      rx = int'($urandom_range(30000)) - 15000;
      ry = int'($urandom_range(30000)) - 15000;
      rr = 13'($urandom);
      rd = 1'($urandom_range(1));
      send(rx, ry, rr, 2'($urandom), 2'($urandom), rd, "R9", 1'b0);
      if ($urandom_range(3) == 0) idle(int'($urandom_range(3)));
    end
    idle(1);
    while (q.size() != 0) @(posedge clk);
    rand_ready = 0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(n_out == n_in, "R9", "sample count", n_out, n_in);
    chk(out_valid == 1'b0, "R9", "no extra output", int'(out_valid), 0);
    finish_up();
  end

endmodule